// File: doc/BRIEF.md
# Pretrigger/Posttrigger Capture Controller

This block steers the writing of a sample stream into a circular sample memory whose size is set per recording. A recording has two parts: the samples written before the trigger (the pretrigger part) and a programmed number of samples written after it (the posttrigger part). The pretrigger length is the memory size minus the posttrigger count. After a start command the controller first fills the whole pretrigger region. Only then does it arm and start watching the trigger input. Once a trigger is accepted it writes exactly the posttrigger count of further samples, stops and raises ready. Software polls the ready flag after a start.

The controller drives the write address and the write enable of the memory. It shows whether the trigger is armed, and it holds the address of the first posttrigger sample so that readout can find where the recording begins. The address wraps modulo the programmed size. A trigger that comes before arming, or after a trigger has already been accepted, has no effect until the next start. A stop command or reset returns the block to idle with ready low.

The sequencer has five states. IDLE waits for a start. PRE writes the pretrigger region. ARMED keeps writing circularly while it waits for a trigger. POST writes the posttrigger samples. DONE holds ready. The transitions are as follows:
- start from any state goes to PRE, or to ARMED when the pretrigger length is zero;
- PRE goes to ARMED on the last pretrigger write;
- ARMED goes to POST on a trigger, or to DONE when the posttrigger count is zero;
- POST goes to DONE on the last posttrigger write;
- stop goes to IDLE from any state and takes priority over start.

Top module: `cap_ctrl`

## Requirements
- R1: After reset, ready_o, armed_o and wr_en_o are 0 and wr_addr_o is 0. In idle, trigger and sample inputs have no effect.
- R2: At start the size is captured, with 0 read as 1 and values above MAX_DEPTH saturated to MAX_DEPTH. A posttrigger count above the size is clamped to the size, which makes the pretrigger length zero, so armed_o is 1 in the cycle after start.
- R3: After start, exactly size minus posttrigger written samples occur before armed_o rises. armed_o is 1 in the cycle after the last pretrigger write.
- R4: A trigger is accepted only while armed_o is 1. A trigger held high during the pretrigger phase or while ready does not change the pretrigger count, ready_o or trig_addr_o.
- R5: On an accepted trigger, trig_addr_o becomes the write address that follows the trigger cycle. This is the address of the first posttrigger sample.
- R6: After the trigger cycle, exactly the clamped posttrigger count of samples is written. ready_o is then 1 and wr_en_o stays 0 until the next start or stop.
- R7: Each write uses wr_addr_o equal to the number of samples written since start, modulo the captured size.
- R8: stop_i returns the block to idle in the next cycle, with ready_o, armed_o and wr_en_o at 0. stop_i wins over start_i.
- R9: start_i restarts a recording from any state, with wr_addr_o at 0 in the next cycle.
- R10: wr_en_o is 1 only when sample_vld_i is 1 in the PRE, ARMED or POST state. Cycles without a valid sample do not advance the address or the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a recording (one-cycle pulse) |
| stop_i | input | 1 | Abort to idle |
| mem_size_i | input | CW | Recording size in samples, captured at start |
| post_cnt_i | input | CW | Posttrigger samples, captured at start |
| sample_vld_i | input | 1 | A sample is present this cycle |
| trig_i | input | 1 | Trigger from the detector |
| wr_addr_o | output | AW | Memory write address |
| wr_en_o | output | 1 | Memory write enable |
| armed_o | output | 1 | Trigger input is being watched |
| ready_o | output | 1 | Recording complete |
| trig_addr_o | output | AW | Address of first posttrigger sample |

## Verification
Recordings are tried with a mid-size split, with posttrigger equal to the size and above it (zero pretrigger), with sizes of 0 and above the maximum, and with gapped sample streams that force the address to wrap. Together these separate a correct pretrigger count from an off-by-one, show that clamping and saturation happen, and show that invalid cycles stall the counts. The trigger is held high during the pretrigger phase and after completion, which exposes a controller that arms early or accepts a second trigger. Directed tests cover stop in mid-recording and from the ready state, restart during the pretrigger phase, and stop colliding with start.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ARMED = 3'd2,
        ST_POST  = 3'd3,
        ST_DONE  = 3'd4
    } cap_state_e;
endpackage

// File: rtl/cap_len_calc.sv
module cap_len_calc #(
    parameter int MAX_DEPTH = 64,
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] size_i,
    input  logic [CW-1:0] post_i,
    output logic [CW-1:0] pre_d_o,
    output logic [CW-1:0] size_q_o,
    output logic [CW-1:0] post_q_o,
    output logic [CW-1:0] pre_q_o
);
    logic [CW-1:0] size_sat;
    logic [CW-1:0] post_clamp;

    always_comb begin
        if (size_i == '0)
            size_sat = CW'(1);
        else if (size_i > CW'(MAX_DEPTH))
            size_sat = CW'(MAX_DEPTH);
        else
            size_sat = size_i;
        post_clamp = (post_i > size_sat) ? size_sat : post_i;
        pre_d_o    = size_sat - post_clamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q_o <= CW'(1);
            post_q_o <= '0;
            pre_q_o  <= CW'(1);
        end else if (load_i) begin
            size_q_o <= size_sat;
            post_q_o <= post_clamp;
            pre_q_o  <= pre_d_o;
        end
    end

    AST_SPLIT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (post_q_o <= size_q_o) && (size_q_o != '0)); // R2
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
    parameter int MAX_DEPTH = 64,
    localparam int CW = $clog2(MAX_DEPTH + 1),
    localparam int AW = $clog2(MAX_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [CW-1:0] size_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] addr_nxt_o
);
    logic at_end;

    always_comb begin
        at_end     = (CW'(addr_o) == (size_i - CW'(1)));
        addr_nxt_o = addr_o;
        if (step_i)
            addr_nxt_o = at_end ? '0 : addr_o + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_o <= '0;
        else if (clear_i)
            addr_o <= '0;
        else
            addr_o <= addr_nxt_o;
    end

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (CW'(addr_o) < size_i)); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(addr_o)); // R10
endmodule

// File: rtl/cap_seq.sv
module cap_seq
    import cap_pkg::*;
#(
    parameter int MAX_DEPTH = 64,
    localparam int CW = $clog2(MAX_DEPTH + 1),
    localparam int AW = $clog2(MAX_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          vld_i,
    input  logic          trig_i,
    input  logic [CW-1:0] pre_d_i,
    input  logic [CW-1:0] pre_q_i,
    input  logic [CW-1:0] post_q_i,
    input  logic [AW-1:0] addr_nxt_i,
    output logic          load_o,
    output logic          wr_en_o,
    output logic          armed_o,
    output logic          ready_o,
    output logic [AW-1:0] trig_addr_o
);
    cap_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          trig_take;

    assign load_o    = start_i && !stop_i;
    assign trig_take = (state_q == ST_ARMED) && trig_i && !start_i && !stop_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stop_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (start_i) begin
            state_d = (pre_d_i == '0) ? ST_ARMED : ST_PRE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_PRE: begin
                    if (vld_i) begin
                        if (cnt_q == pre_q_i - CW'(1)) begin
                            state_d = ST_ARMED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_ARMED: begin
                    if (trig_i) begin
                        state_d = (post_q_i == '0) ? ST_DONE : ST_POST;
                        cnt_d   = '0;
                    end
                end
                ST_POST: begin
                    if (vld_i) begin
                        if (cnt_q == post_q_i - CW'(1)) begin
                            state_d = ST_DONE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trig_addr_o <= '0;
        else if (trig_take)
            trig_addr_o <= addr_nxt_i;
    end

    always_comb begin
        wr_en_o = 1'b0;
        armed_o = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PRE:   wr_en_o = vld_i;
            ST_ARMED: begin
                wr_en_o = vld_i;
                armed_o = 1'b1;
            end
            ST_POST:  wr_en_o = vld_i;
            ST_DONE:  ready_o = 1'b1;
            default:  ;
        endcase
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE)); // R8
    AST_DONE_HOLDS_TADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> $stable(trig_addr_o)); // R4
    AST_ARM_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE && !start_i && !stop_i) |=> (state_q == ST_PRE || state_q == ST_ARMED)); // R3
    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed_o, ready_o})); // R6
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl #(
    parameter int MAX_DEPTH = 64,
    localparam int CW = $clog2(MAX_DEPTH + 1),
    localparam int AW = $clog2(MAX_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [CW-1:0] mem_size_i,
    input  logic [CW-1:0] post_cnt_i,
    input  logic          sample_vld_i,
    input  logic          trig_i,
    output logic [AW-1:0] wr_addr_o,
    output logic          wr_en_o,
    output logic          armed_o,
    output logic          ready_o,
    output logic [AW-1:0] trig_addr_o
);
    logic [CW-1:0] pre_d, size_q, post_q, pre_q;
    logic [AW-1:0] addr_nxt;
    logic          load;

    cap_len_calc #(.MAX_DEPTH(MAX_DEPTH)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .size_i   (mem_size_i),
        .post_i   (post_cnt_i),
        .pre_d_o  (pre_d),
        .size_q_o (size_q),
        .post_q_o (post_q),
        .pre_q_o  (pre_q)
    );

    cap_addr_gen #(.MAX_DEPTH(MAX_DEPTH)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (load || stop_i),
        .step_i     (wr_en_o),
        .size_i     (size_q),
        .addr_o     (wr_addr_o),
        .addr_nxt_o (addr_nxt)
    );

    cap_seq #(.MAX_DEPTH(MAX_DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .vld_i       (sample_vld_i),
        .trig_i      (trig_i),
        .pre_d_i     (pre_d),
        .pre_q_i     (pre_q),
        .post_q_i    (post_q),
        .addr_nxt_i  (addr_nxt),
        .load_o      (load),
        .wr_en_o     (wr_en_o),
        .armed_o     (armed_o),
        .ready_o     (ready_o),
        .trig_addr_o (trig_addr_o)
    );

    AST_WREN_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sample_vld_i); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (wr_addr_o == '0) && !ready_o); // R9
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !ready_o && !armed_o && !wr_en_o); // R8
endmodule

// File: tb/cap_ctrl_bench.sv
module cap_ctrl_bench;
    localparam int MAXD = 64;
    localparam int CW = $clog2(MAXD + 1);
    localparam int AW = $clog2(MAXD);
    localparam int NV = 8;
    // size, post, armed delay, gapped stream, expected pre, expected post
    localparam int VEC [NV][6] = '{
        '{8,   3,  2, 0,  5, 3},
        '{8,   8,  0, 0,  0, 8},
        '{8,  20,  1, 0,  0, 8},
        '{5,   2,  7, 1,  3, 2},
        '{64, 10, 30, 0, 54, 10},
        '{0,   0,  0, 0,  1, 0},
        '{100, 5,  3, 0, 59, 5},
        '{3,   1,  4, 1,  2, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, sample_vld_i = 1'b0, trig_i = 1'b0;
    logic [CW-1:0] mem_size_i = '0, post_cnt_i = '0;
    logic [AW-1:0] wr_addr_o, trig_addr_o;
    logic wr_en_o, armed_o, ready_o;

    int checks = 0;
    int errors = 0;
    int wcount;
    int addr_bad;
    bit phase;

    always #2.5 clk = ~clk;

    cap_ctrl #(.MAX_DEPTH(MAXD)) u_cap_ctrl (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // inputs already driven; sample outputs, count writes, advance one edge
    task automatic cyc(input int size);
        #1;
        if (wr_en_o) begin
            if (int'(wr_addr_o) != (wcount % size)) addr_bad++;
            wcount++;
        end
        @(posedge clk);
        #1;
    endtask

    function automatic int eff_size(input int s);
        if (s == 0) return 1;
        if (s > MAXD) return MAXD;
        return s;
    endfunction

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int sz, pw, pc;
        repeat (3) @(posedge clk);
        #1;
        chk(!ready_o && !armed_o && !wr_en_o && wr_addr_o == 0, "R1", {ready_o, armed_o, wr_en_o}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        trig_i = 1; sample_vld_i = 1;
        #1;
        chk(!wr_en_o, "R1 idle no write", wr_en_o, 0);
        @(posedge clk); #1;
        chk(!ready_o && !armed_o, "R1 idle trigger ignored", {ready_o, armed_o}, 0);
        trig_i = 0;

        for (int v = 0; v < NV; v++) begin
            sz = eff_size(VEC[v][0]);
            wcount = 0; addr_bad = 0; phase = 0;
            mem_size_i = CW'(VEC[v][0]); post_cnt_i = CW'(VEC[v][1]);
            start_i = 1; sample_vld_i = 0; trig_i = 0;
            @(posedge clk); #1;
            start_i = 0;
            if (VEC[v][4] == 0)
                chk(armed_o, "R2 zero pretrigger arms at once", armed_o, 1);
            for (int k = 0; k < 400 && !armed_o; k++) begin
                trig_i = 1;   // early trigger must be ignored (R4)
                phase = ~phase;
                sample_vld_i = VEC[v][3] ? phase : 1'b1;
                cyc(sz);
            end
            trig_i = 0;
            chk(wcount == VEC[v][4], "R3 pretrigger writes before arm", wcount, VEC[v][4]);
            for (int k = 0; k < VEC[v][2]; k++) begin
                phase = ~phase;
                sample_vld_i = VEC[v][3] ? phase : 1'b1;
                cyc(sz);
            end
            chk(armed_o && !ready_o, "R4 still armed while waiting", armed_o, 1);
            trig_i = 1; sample_vld_i = 1;
            cyc(sz);
            trig_i = 0;
            chk(int'(trig_addr_o) == (wcount % sz), "R5 trigger address", trig_addr_o, wcount % sz);
            pw = wcount;
            for (int k = 0; k < 400 && !ready_o; k++) begin
                phase = ~phase;
                sample_vld_i = VEC[v][3] ? phase : 1'b1;
                cyc(sz);
            end
            pc = wcount - pw;
            chk(ready_o && pc == VEC[v][5], "R6 posttrigger count", pc, VEC[v][5]);
            trig_i = 1; sample_vld_i = 1;
            #1;
            chk(!wr_en_o, "R6 no write when ready", wr_en_o, 0);
            @(posedge clk); #1;
            chk(ready_o && int'(trig_addr_o) == (pw % sz), "R4 late trigger ignored", trig_addr_o, pw % sz);
            trig_i = 0;
            chk(addr_bad == 0, "R7 wrap addressing", addr_bad, 0);
        end

        // R10: gaps stall address
        mem_size_i = 16; post_cnt_i = 4; start_i = 1; sample_vld_i = 0;
        @(posedge clk); #1; start_i = 0;
        sample_vld_i = 1; @(posedge clk); #1;
        sample_vld_i = 1; @(posedge clk); #1;
        sample_vld_i = 0; #1;
        chk(!wr_en_o, "R10 no write without sample", wr_en_o, 0);
        @(posedge clk); #1;
        chk(wr_addr_o == 2, "R10 address stalls", wr_addr_o, 2);
        // R9: restart mid pretrigger
        start_i = 1; @(posedge clk); #1; start_i = 0;
        chk(wr_addr_o == 0 && !armed_o, "R9 restart clears address", wr_addr_o, 0);
        sample_vld_i = 1; repeat (3) @(posedge clk); #1;
        // R8: stop mid recording, stop beats start
        stop_i = 1; start_i = 1; @(posedge clk); #1; stop_i = 0; start_i = 0;
        #1;
        chk(!wr_en_o && !armed_o && !ready_o && wr_addr_o == 0, "R8 stop aborts", {wr_en_o, armed_o, ready_o}, 0);
        repeat (3) @(posedge clk); #1;
        chk(!wr_en_o && wr_addr_o == 0, "R8 stays idle", wr_addr_o, 0);
        // R8: stop from ready
        mem_size_i = 2; post_cnt_i = 2; start_i = 1; @(posedge clk); #1; start_i = 0;
        trig_i = 1; @(posedge clk); #1; trig_i = 0;
        repeat (2) @(posedge clk); #1;
        chk(ready_o, "R6 small capture ready", ready_o, 1);
        stop_i = 1; @(posedge clk); #1; stop_i = 0;
        chk(!ready_o, "R8 stop clears ready", ready_o, 0);
        sample_vld_i = 0;
        finish_run();
    end
endmodule